// File: doc/BRIEF.md
# Transmit Frame Start Controller

This block sits between the host command path and an Ethernet MAC. It decides when a queued transmit frame may go onto the wire, and it tells the MAC how to shape that frame. The host writes a command word together with a frame length. A buffer-fill counter reports how many bytes of the frame have arrived so far. When the programmed early-start point is reached, or the whole frame is present, the block issues a one-cycle start strobe.

While the frame is on the wire, the block counts the collisions the MAC reports. It abandons the frame once the selected collision limit is reached. A forced command flushes queued frames. If a frame is already being sent, a forced command also orders that frame cut short with a corrupted CRC.

The block also drives two shaping outputs to the MAC. One gives the number of pad bytes to insert. The other enables CRC append. Both follow from the stored length and the inhibit-CRC and pad-disable bits. The CRC generator, the backoff timer and the buffer memory live outside the block.

Top module: `tx_start_ctl`

## Requirements
- R1: After reset, `cmd_reg` reads 16'h0009, every strobe output is low, and no frame is armed.
- R2: Command bits [7:6] select the start point. 00 means 5 bytes buffered, 01 means 381, 10 means 1021 and 11 means the whole frame. `tx_start` rises one cycle after the first cycle in which `buf_cnt` reaches that point, or reaches the frame length if that comes first.
- R3: `tx_start` is a single-cycle pulse and fires at most once per accepted command.
- R4: A command with a length below 3 never produces `tx_start`.
- R5: A command with bit 8 (force) set pulses `buf_flush` in the next cycle. If a frame was being sent at that moment, `abort_badcrc` also pulses in that same next cycle. That is far inside 64 bit times.
- R6: A command without force that is written while a frame is being sent is ignored, and `cmd_reg` keeps its value.
- R7: With bit 9 (one-collision) set, the first collision during sending pulses `give_up` in the next cycle and the frame is dropped.
- R8: With bit 9 clear, `give_up` pulses on the 16th collision of a frame. Up to 15 collisions leave the frame active, and `tx_done` ends it normally.
- R9: With bit 13 (pad-disable) clear and a length below 60, `pad_cnt` equals 60 minus the length. Otherwise `pad_cnt` is 0.
- R10: `crc_en` is high exactly when bit 12 (inhibit-CRC) of the stored command is clear.
- R11: An accepted command clears the collision count, so a re-issued frame again tolerates 15 collisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command: [7:6] start point, [8] force, [9] one-collision, [12] inhibit-CRC, [13] pad-disable |
| len_in | input | 11 | Frame length in bytes, taken with `cmd_wr` |
| buf_cnt | input | 11 | Bytes of the current frame held in the buffer |
| col_in | input | 1 | Collision indication from the MAC, one pulse per collision |
| tx_done | input | 1 | Frame finished successfully |
| cmd_reg | output | 16 | Stored command word; the low six bits are a fixed identifier 6'b001001 |
| tx_start | output | 1 | Start strobe |
| pad_cnt | output | 11 | Pad bytes to insert |
| crc_en | output | 1 | Append CRC |
| buf_flush | output | 1 | Discard queued frames |
| abort_badcrc | output | 1 | Cut the current frame and end it with a bad CRC |
| give_up | output | 1 | Collision limit reached; frame dropped |

## Verification
The bench steps `buf_cnt` across each of the four start points, including a short frame whose length falls below its own start point. A design that compares against the wrong threshold, or never falls back to the frame length, would start early, start late or never start at all.

It drives exactly 15 collisions and then a 16th. It also issues a forced command partway through a collision run. An off-by-one limit, or a count that is not cleared by a new command, would drop the frame a collision too early or too late.

Commands are written while a frame is being sent, both with and without force. A wrong design would overwrite the running command or fail to order the bad-CRC abort. Lengths of 2, 40 and 59 bytes exercise the refusal of very short frames and the padding arithmetic against the pad-disable bit.

// File: rtl/tx_start_pkg.sv
package tx_start_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    localparam int B_THR  = 6;
    localparam int B_FRC  = 8;
    localparam int B_ONE  = 9;
    localparam int B_INH  = 12;
    localparam int B_PDIS = 13;
    localparam logic [5:0] CMD_ID = 6'b001001;
endpackage

// File: rtl/tx_start_thresh.sv
module tx_start_thresh #(
    parameter int LEN_W = 11,
    parameter int LVL0  = 5,
    parameter int LVL1  = 381,
    parameter int LVL2  = 1021
) (
    input  logic [1:0]       sel,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] buf_cnt,
    output logic             hit
);
    localparam int NLVL = 4;
    localparam int LVLS [NLVL-1] = '{LVL0, LVL1, LVL2};

    logic [LEN_W-1:0] lvl [NLVL];

    for (genvar g = 0; g < NLVL - 1; g++) begin : g_fixed
        assign lvl[g] = LEN_W'(LVLS[g]);
    end
    assign lvl[NLVL-1] = len;

    assign hit = (buf_cnt >= lvl[sel]) || (buf_cnt >= len);
endmodule

// File: rtl/tx_frame_shape.sv
module tx_frame_shape #(
    parameter int LEN_W   = 11,
    parameter int PAD_MIN = 60
) (
    input  logic             pad_dis,
    input  logic             inh_crc,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] pad_cnt,
    output logic             crc_en
);
    localparam logic [LEN_W-1:0] PMIN = LEN_W'(PAD_MIN);

    always_comb begin
        pad_cnt = '0;
        if (!pad_dis && (len < PMIN)) pad_cnt = PMIN - len;
        crc_en = !inh_crc;
    end
endmodule

// File: rtl/tx_start_ctl.sv
module tx_start_ctl
    import tx_start_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int COL_LIMIT = 16,
    parameter int PAD_MIN   = 60,
    parameter int MIN_LEN   = 3,
    parameter int LVL0      = 5,
    parameter int LVL1      = 381,
    parameter int LVL2      = 1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [15:0]      cmd_word,
    input  logic [LEN_W-1:0] len_in,
    input  logic [LEN_W-1:0] buf_cnt,
    input  logic             col_in,
    input  logic             tx_done,
    output logic [15:0]      cmd_reg,
    output logic             tx_start,
    output logic [LEN_W-1:0] pad_cnt,
    output logic             crc_en,
    output logic             buf_flush,
    output logic             abort_badcrc,
    output logic             give_up
);
    localparam int CW = $clog2(COL_LIMIT + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [1:0]       thr;
        logic             frc;
        logic             one;
        logic             inh;
        logic             pdis;
        logic [LEN_W-1:0] len;
        logic [CW-1:0]    col;
        logic             start;
        logic             abort;
        logic             flush;
        logic             give;
    } ctl_t;

    ctl_t q, d;
    logic hit;
    logic accept;
    logic [CW-1:0] col_inc;
    logic [CW-1:0] lim;
    logic unused_bits;

    assign unused_bits = ^{cmd_word[15:14], cmd_word[11:10], cmd_word[5:0]};

    tx_start_thresh #(
        .LEN_W(LEN_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2)
    ) u_thr (
        .sel(q.thr), .len(q.len), .buf_cnt(buf_cnt), .hit(hit)
    );

    tx_frame_shape #(
        .LEN_W(LEN_W), .PAD_MIN(PAD_MIN)
    ) u_shape (
        .pad_dis(q.pdis), .inh_crc(q.inh), .len(q.len),
        .pad_cnt(pad_cnt), .crc_en(crc_en)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        d.flush = 1'b0;
        d.give  = 1'b0;
        accept  = cmd_wr && !((q.st == ST_SEND) && !cmd_word[B_FRC]);
        col_inc = q.col + 1'b1;
        lim     = q.one ? CW'(1) : CW'(COL_LIMIT);
        if (accept) begin
            d.flush = cmd_word[B_FRC];
            d.abort = cmd_word[B_FRC] && (q.st == ST_SEND);
            d.thr   = cmd_word[B_THR +: 2];
            d.frc   = cmd_word[B_FRC];
            d.one   = cmd_word[B_ONE];
            d.inh   = cmd_word[B_INH];
            d.pdis  = cmd_word[B_PDIS];
            d.len   = len_in;
            d.col   = '0;
            d.st    = (len_in >= LEN_W'(MIN_LEN)) ? ST_WAIT : ST_IDLE;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    if (hit) begin
                        d.start = 1'b1;
                        d.st    = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_done) begin
                        d.st  = ST_IDLE;
                        d.col = '0;
                    end else if (col_in) begin
                        if (col_inc == lim) begin
                            d.give = 1'b1;
                            d.st   = ST_IDLE;
                            d.col  = '0;
                        end else begin
                            d.col = col_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign cmd_reg      = {2'b00, q.pdis, q.inh, 2'b00, q.one, q.frc, q.thr, CMD_ID};
    assign tx_start     = q.start;
    assign buf_flush    = q.flush;
    assign abort_badcrc = q.abort;
    assign give_up      = q.give;

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    a_r4_no_short_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (q.len >= LEN_W'(MIN_LEN)));
    a_r5_abort_after_force: assert property (@(posedge clk) disable iff (!rst_n)
        abort_badcrc |-> (buf_flush && $past(cmd_wr && cmd_word[B_FRC])));
    a_r7_give_up_drops: assert property (@(posedge clk) disable iff (!rst_n)
        give_up |-> (q.st == ST_IDLE));
    a_r8_col_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.col < CW'(COL_LIMIT));
    a_r9_pad_total: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_cnt != '0) |-> ((q.len + pad_cnt) == LEN_W'(PAD_MIN)));
endmodule

// File: tb/sim_tx_start_ctl.sv
`timescale 1ns/1ps
module sim_tx_start_ctl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [10:0] len_in = '0;
    logic [10:0] buf_cnt = '0;
    logic        col_in = 1'b0;
    logic        tx_done = 1'b0;
    logic [15:0] cmd_reg;
    logic        tx_start, crc_en, buf_flush, abort_badcrc, give_up;
    logic [10:0] pad_cnt;

    tx_start_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .len_in(len_in), .buf_cnt(buf_cnt), .col_in(col_in), .tx_done(tx_done),
        .cmd_reg(cmd_reg), .tx_start(tx_start), .pad_cnt(pad_cnt), .crc_en(crc_en),
        .buf_flush(buf_flush), .abort_badcrc(abort_badcrc), .give_up(give_up)
    );

    int checks = 0;
    int fails = 0;

    // reference model: 0 idle, 1 armed, 2 sending
    int m_st = 0, m_thr = 0, m_frc = 0, m_one = 0, m_inh = 0, m_pdis = 0;
    int m_len = 0, m_col = 0;
    int m_start = 0, m_abort = 0, m_flush = 0, m_give = 0;
    int n_start = 0, n_give = 0, n_abort = 0, n_flush = 0;

    always @(posedge clk) begin
        int thrv;
        int lim;
        bit acc;
        if (!rst_n) begin
            m_st = 0; m_thr = 0; m_frc = 0; m_one = 0; m_inh = 0; m_pdis = 0;
            m_len = 0; m_col = 0; m_start = 0; m_abort = 0; m_flush = 0; m_give = 0;
        end else begin
            m_start = 0; m_abort = 0; m_flush = 0; m_give = 0;
            acc = cmd_wr && !(m_st == 2 && !cmd_word[8]);
            if (acc) begin
                m_flush = cmd_word[8];
                m_abort = (cmd_word[8] && m_st == 2) ? 1 : 0;
                m_thr = cmd_word[7:6]; m_frc = cmd_word[8]; m_one = cmd_word[9];
                m_inh = cmd_word[12]; m_pdis = cmd_word[13];
                m_len = len_in; m_col = 0;
                m_st = (len_in >= 3) ? 1 : 0;
            end else if (m_st == 1) begin
                case (m_thr)
                    0: thrv = 5;
                    1: thrv = 381;
                    2: thrv = 1021;
                    default: thrv = m_len;
                endcase
                if (buf_cnt >= thrv || buf_cnt >= m_len) begin
                    m_start = 1; m_st = 2;
                end
            end else if (m_st == 2) begin
                lim = m_one ? 1 : 16;
                if (tx_done) begin
                    m_st = 0; m_col = 0;
                end else if (col_in) begin
                    m_col = m_col + 1;
                    if (m_col == lim) begin
                        m_give = 1; m_st = 0; m_col = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int e_reg;
        int e_pad;
        e_reg = (m_pdis << 13) | (m_inh << 12) | (m_one << 9) | (m_frc << 8) | (m_thr << 6) | 9;
        e_pad = (!m_pdis && m_len < 60) ? 60 - m_len : 0;
        chk(cmd_reg == e_reg, "R1 R6 cmd_reg", cmd_reg, e_reg);
        chk(tx_start == m_start, "R2 R3 tx_start", tx_start, m_start);
        chk(buf_flush == m_flush, "R5 buf_flush", buf_flush, m_flush);
        chk(abort_badcrc == m_abort, "R5 abort_badcrc", abort_badcrc, m_abort);
        chk(give_up == m_give, "R7 R8 give_up", give_up, m_give);
        chk(pad_cnt == e_pad, "R9 pad_cnt", pad_cnt, e_pad);
        chk(crc_en == !m_inh, "R10 crc_en", crc_en, !m_inh);
        if (tx_start) n_start++;
        if (give_up) n_give++;
        if (abort_badcrc) n_abort++;
        if (buf_flush) n_flush++;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input int thr, input bit frc, input bit one, input bit inh,
                       input bit pdis, input int len);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = 16'(9 | (thr << 6) | (int'(frc) << 8) | (int'(one) << 9)
                       | (int'(inh) << 12) | (int'(pdis) << 13));
        len_in = 11'(len);
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic ramp(input int upto, input int step);
        for (int v = 0; v <= upto; v += step) begin
            @(negedge clk);
            buf_cnt = 11'(v);
        end
        @(negedge clk);
        buf_cnt = 11'(upto);
        cyc(3);
    endtask

    task automatic pulse_col(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); col_in = 1'b1;
            @(negedge clk); col_in = 1'b0;
        end
        cyc(1);
    endtask

    task automatic finish_tx();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        cyc(1);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        cyc(3);
        chk(cmd_reg == 16'h0009, "R1 reset value", cmd_reg, 16'h0009);
        chk(tx_start == 0 && give_up == 0 && abort_badcrc == 0, "R1 strobes low", tx_start, 0);
        rst_n = 1'b1;
        cyc(2);

        // R2: each start point
        n_start = 0; buf_cnt = 0;
        cmd(0, 0, 0, 0, 0, 100); ramp(100, 1); finish_tx();
        chk(n_start == 1, "R2 code 00", n_start, 1);
        n_start = 0; buf_cnt = 0;
        cmd(1, 0, 0, 0, 0, 500); ramp(500, 20); finish_tx();
        chk(n_start == 1, "R2 code 01", n_start, 1);
        n_start = 0; buf_cnt = 0;
        cmd(2, 0, 0, 0, 0, 1200); ramp(1200, 50); finish_tx();
        chk(n_start == 1, "R2 code 10", n_start, 1);
        n_start = 0; buf_cnt = 0;
        cmd(3, 0, 0, 0, 0, 200); ramp(200, 10); cyc(5);
        chk(n_start == 1, "R3 once per command", n_start, 1);
        finish_tx();
        // short frame below its start point: starts on completion
        n_start = 0; buf_cnt = 0;
        cmd(2, 0, 0, 0, 0, 300); ramp(300, 25); finish_tx();
        chk(n_start == 1, "R2 frame complete", n_start, 1);

        // R9 / R10 shaping
        buf_cnt = 0;
        cmd(0, 0, 0, 1, 0, 40); cyc(1);
        chk(pad_cnt == 20, "R9 pad to 60", pad_cnt, 20);
        chk(crc_en == 0, "R10 inhibit", crc_en, 0);
        ramp(40, 4); finish_tx();
        buf_cnt = 0;
        cmd(0, 0, 0, 0, 1, 59); cyc(1);
        chk(pad_cnt == 0, "R9 pad disabled", pad_cnt, 0);
        chk(crc_en == 1, "R10 crc on", crc_en, 1);
        ramp(59, 10); finish_tx();

        // R4: too short
        n_start = 0; buf_cnt = 0;
        cmd(3, 0, 0, 0, 0, 2); buf_cnt = 2; cyc(6);
        chk(n_start == 0, "R4 length 2", n_start, 0);

        // R6 / R5 / R11 / R8
        n_start = 0; n_give = 0; n_abort = 0; buf_cnt = 0;
        cmd(0, 0, 0, 0, 0, 100); ramp(100, 10);
        cmd(3, 0, 0, 0, 0, 300); cyc(2);
        chk(cmd_reg == 16'h0009, "R6 ignored while sending", cmd_reg, 16'h0009);
        pulse_col(10);
        cmd(0, 1, 0, 0, 0, 100); cyc(1);
        chk(n_abort == 1, "R5 abort on force", n_abort, 1);
        cyc(3);
        pulse_col(15);
        chk(n_give == 0, "R11 count cleared", n_give, 0);
        pulse_col(1);
        chk(n_give == 1, "R8 16th collision", n_give, 1);

        // R7
        n_give = 0; buf_cnt = 0;
        cmd(0, 0, 1, 0, 0, 100); ramp(100, 20);
        pulse_col(1);
        chk(n_give == 1, "R7 one collision", n_give, 1);

        // R5 force while armed: flush only
        n_abort = 0; n_flush = 0; buf_cnt = 0;
        cmd(3, 0, 0, 0, 0, 400); cyc(2);
        cmd(3, 1, 0, 0, 0, 400); cyc(2);
        chk(n_flush == 1 && n_abort == 0, "R5 force while armed", n_abort, 0);

        cyc(4);
        summary();
    end
endmodule